// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block places incoming packets into a circular receive area of local buffer memory that is organised as 256-byte pages. The host programs four page registers while reception is stopped: the first ring page, the page at which the ring ends, the boundary (the last page the host has finished reading) and the current page (where the next packet starts). The receive path then streams bytes in, with strobes that mark the first and last byte of a packet. The block turns each byte into a local memory write and forms the address from a page number in the upper bits and a byte offset in the low 8 bits.

Each packet reserves the first four bytes of its first page for a header, so payload starts at offset 4. When a page fills, writing moves to the following page and wraps from the end page back to the first ring page. If writing would enter the boundary page, the block drops the packet and leaves the current page as it was, so that data the host has not yet read stays intact. After the last byte it writes the header and moves the current page past the packet.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset, the registers read as ring start 0x46, ring end 0x60, boundary 0x46 and current page 0x47. Register select 0 is ring start, 1 is ring end, 2 is boundary and 3 is current page. Reads are combinational on `reg_rdata`.
- R2: A register write takes effect only while `rx_enable` is low and no packet is in progress. A write while `rx_enable` is high leaves the register unchanged.
- R3: The first byte of a packet (`wr_valid` and `wr_sop` together while `rx_enable` is high) is written at address {current page, 0x04}. Each later byte goes to the next offset.
- R4: After a byte is written at offset 0xFF, the next byte goes to offset 0 of the next page. The next page after P is the ring start when P+1 equals the ring end, and P+1 otherwise.
- R5: A byte that would be written at offset 0 of the page equal to the boundary is not written. The rest of the packet, up to and including its `wr_eop` byte, is discarded. `rx_ovf` is high for exactly one cycle, no header is written, `pkt_done` stays low and the current page is unchanged.
- R6: After the `wr_eop` byte of a packet that was not dropped, four header writes follow in four consecutive cycles at offsets 0 to 3 of the packet's first page. They hold status 0x01, the next-packet page, then the low and high bytes of the payload length plus 4.
- R7: In the cycle after the last header write, `pkt_done` is high for one cycle and the current page holds the page after the last page written. If the last byte landed at offset 0xFF, this is the page after that one. The header's next-packet page carries the same value.
- R8: A start-of-packet byte while `rx_enable` is low produces no memory write, and that packet leaves the current page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Reception running; register writes are frozen while high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | PAGE_W | Register write data |
| reg_rdata | output | PAGE_W | Selected register value |
| wr_valid | input | 1 | Receive byte valid |
| wr_sop | input | 1 | Byte is the first of a packet |
| wr_eop | input | 1 | Byte is the last of a packet |
| wr_data | input | 8 | Receive byte |
| mem_we | output | 1 | Local memory write enable |
| mem_addr | output | PAGE_W+8 | Local memory byte address |
| mem_wdata | output | 8 | Local memory write data |
| pkt_done | output | 1 | One-cycle pulse: packet stored and current page advanced |
| rx_ovf | output | 1 | One-cycle pulse: packet dropped at the boundary |

## Verification
The assertions rely on the host keeping the ring consistent: ring start below ring end, with current page and boundary both inside that range. Given that, no write can land on the end page. They also rely on the receive path raising `wr_sop` only on a packet's first byte and sending nothing during the four header cycles. The directed tests program only in-range page values while reception is stopped, and wait at least six idle cycles after each last byte before the next action. Only in the test that stops reception does a start-of-packet byte arrive while stopped.

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr #(
  parameter int PAGE_W = 8,
  parameter logic [PAGE_W-1:0] RST_START = 'h46,
  parameter logic [PAGE_W-1:0] RST_STOP  = 'h60,
  parameter logic [PAGE_W-1:0] RST_BNDRY = 'h46,
  parameter logic [PAGE_W-1:0] RST_CURR  = 'h47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [PAGE_W-1:0] reg_wdata,
  output logic [PAGE_W-1:0] reg_rdata,
  input  logic              wr_valid,
  input  logic              wr_sop,
  input  logic              wr_eop,
  input  logic [7:0]        wr_data,
  output logic              mem_we,
  output logic [PAGE_W+7:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              pkt_done,
  output logic              rx_ovf
);
  localparam logic [PAGE_W-1:0] PG_ONE = 1;

  typedef enum logic [1:0] {S_IDLE, S_RX, S_DROP, S_HDR} st_t;

  st_t               st_q;
  logic [PAGE_W-1:0] pstart_q, pstop_q, bnry_q, curr_q, wpage_q, ppage_q;
  logic [7:0]        off_q;
  logic [15:0]       cnt_q;
  logic [1:0]        hidx_q;
  logic              done_q, ovf_q;

  function automatic logic [PAGE_W-1:0] nxt(input logic [PAGE_W-1:0] p);
    return (p + PG_ONE == pstop_q) ? pstart_q : p + PG_ONE;
  endfunction

  wire              reg_ok   = reg_we && !rx_enable && st_q == S_IDLE;
  wire              start    = st_q == S_IDLE && rx_enable && wr_valid && wr_sop;
  wire              blocked  = off_q == 8'd0 && wpage_q == bnry_q;
  wire              rx_byte  = st_q == S_RX && wr_valid;
  wire [PAGE_W-1:0] end_page = (off_q == 8'd0) ? wpage_q : nxt(wpage_q);
  wire [15:0]       hlen     = cnt_q + 16'd4;

  assign pkt_done = done_q;
  assign rx_ovf   = ovf_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = pstart_q;
      2'd1:    reg_rdata = pstop_q;
      2'd2:    reg_rdata = bnry_q;
      default: reg_rdata = curr_q;
    endcase
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = {curr_q, 8'd4};
    mem_wdata = wr_data;
    if (start) begin
      mem_we = 1'b1;
    end else if (rx_byte && !blocked) begin
      mem_we   = 1'b1;
      mem_addr = {wpage_q, off_q};
    end else if (st_q == S_HDR) begin
      mem_we   = 1'b1;
      mem_addr = {ppage_q, 6'd0, hidx_q};
      case (hidx_q)
        2'd0:    mem_wdata = 8'h01;
        2'd1:    mem_wdata = 8'(end_page);
        2'd2:    mem_wdata = hlen[7:0];
        default: mem_wdata = hlen[15:8];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      pstart_q <= RST_START;
      pstop_q  <= RST_STOP;
      bnry_q   <= RST_BNDRY;
      curr_q   <= RST_CURR;
      wpage_q  <= '0;
      ppage_q  <= '0;
      off_q    <= '0;
      cnt_q    <= '0;
      hidx_q   <= '0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      if (reg_ok) begin
        case (reg_addr)
          2'd0:    pstart_q <= reg_wdata;
          2'd1:    pstop_q  <= reg_wdata;
          2'd2:    bnry_q   <= reg_wdata;
          default: curr_q   <= reg_wdata;
        endcase
      end
      case (st_q)
        S_IDLE: if (start) begin
          wpage_q <= curr_q;
          ppage_q <= curr_q;
          off_q   <= 8'd5;
          cnt_q   <= 16'd1;
          hidx_q  <= 2'd0;
          st_q    <= wr_eop ? S_HDR : S_RX;
        end
        S_RX: if (wr_valid) begin
          if (blocked) begin
            ovf_q <= 1'b1;
            st_q  <= wr_eop ? S_IDLE : S_DROP;
          end else begin
            off_q <= off_q + 8'd1;
            cnt_q <= cnt_q + 16'd1;
            if (off_q == 8'hFF) wpage_q <= nxt(wpage_q);
            if (wr_eop) st_q <= S_HDR;
          end
        end
        S_DROP: if (wr_valid && wr_eop) st_q <= S_IDLE;
        default: begin
          hidx_q <= hidx_q + 2'd1;
          if (hidx_q == 2'd3) begin
            curr_q <= end_page;
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

module rx_ring_mgr_chk #(parameter int PAGE_W = 8) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_enable,
  input logic              reg_we,
  input logic              pkt_done,
  input logic              rx_ovf,
  input logic              mem_we,
  input logic [PAGE_W+7:0] mem_addr,
  input logic [PAGE_W-1:0] curr,
  input logic [PAGE_W-1:0] pstart,
  input logic [PAGE_W-1:0] pstop,
  input logic [PAGE_W-1:0] bnry
);
  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && rx_enable) |=> ($stable(pstart) && $stable(pstop) && $stable(bnry)));

  p_stop_page_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[PAGE_W+7:8] != pstop));

  p_ovf_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> !rx_ovf);

  p_ovf_keeps_curr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |-> $stable(curr));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);

  p_done_excl_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_done && rx_ovf));
endmodule

bind rx_ring_mgr rx_ring_mgr_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .reg_we(reg_we),
  .pkt_done(pkt_done), .rx_ovf(rx_ovf), .mem_we(mem_we), .mem_addr(mem_addr),
  .curr(curr_q), .pstart(pstart_q), .pstop(pstop_q), .bnry(bnry_q)
);

// File: tb/rx_ring_mgr_bench.sv
module rx_ring_mgr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_enable = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0;
  logic [7:0]  wr_data = 8'd0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        pkt_done, rx_ovf;

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  int ovf_cnt = 0;
  logic [7:0] mem [int];

  always #4 clk = ~clk;

  rx_ring_mgr u_rx_ring_mgr (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_data(wr_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pkt_done(pkt_done), .rx_ovf(rx_ovf)
  );

  always @(posedge clk) begin
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    if (pkt_done) done_cnt++;
    if (rx_ovf) ovf_cnt++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int rdm(int a);
    return mem.exists(a) ? int'(mem[a]) : -1;
  endfunction

  task automatic rreg(input logic [1:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic setup(input logic [7:0] st, sp, bn, cu);
    @(negedge clk);
    rx_enable = 1'b0;
    wreg(2'd0, st); wreg(2'd1, sp); wreg(2'd2, bn); wreg(2'd3, cu);
    @(negedge clk);
    rx_enable = 1'b1;
    mem.delete();
  endtask

  task automatic send(int n, logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_sop = (i == 0); wr_eop = (i == n - 1);
      wr_data = 8'(seed + i);
    end
    @(negedge clk);
    wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic good_pkt(string req, int n, logic [7:0] seed, int cu, int st, int sp, int nx);
    int p = cu, o = 4, bad = 0, d0 = done_cnt, v;
    send(n, seed);
    for (int i = 0; i < n; i++) begin
      if (rdm(p * 256 + o) != int'(8'(seed + i))) bad++;
      o++;
      if (o == 256) begin o = 0; p = (p + 1 == sp) ? st : p + 1; end
    end
    chk({req, " payload mismatches"}, bad, 0);
    chk({req, " R6 header status"}, rdm(cu * 256), 8'h01);
    chk({req, " R6 header next page"}, rdm(cu * 256 + 1), nx);
    chk({req, " R6 header length lo"}, rdm(cu * 256 + 2), (n + 4) & 8'hFF);
    chk({req, " R6 header length hi"}, rdm(cu * 256 + 3), (n + 4) >> 8);
    chk({req, " R7 done pulses"}, done_cnt - d0, 1);
    rreg(2'd3, v);
    chk({req, " R7 current page"}, v, nx);
  endtask

  task automatic t_reset();
    int v;
    rreg(2'd0, v); chk("R1 start", v, 8'h46);
    rreg(2'd1, v); chk("R1 stop", v, 8'h60);
    rreg(2'd2, v); chk("R1 boundary", v, 8'h46);
    rreg(2'd3, v); chk("R1 current", v, 8'h47);
  endtask

  task automatic t_regs();
    int v;
    wreg(2'd2, 8'h55);
    rreg(2'd2, v); chk("R2 write while stopped", v, 8'h55);
    @(negedge clk) rx_enable = 1'b1;
    wreg(2'd2, 8'h33);
    wreg(2'd0, 8'h10);
    rreg(2'd2, v); chk("R2 boundary write ignored while running", v, 8'h55);
    rreg(2'd0, v); chk("R2 start write ignored while running", v, 8'h46);
    @(negedge clk) rx_enable = 1'b0;
    wreg(2'd2, 8'h46);
  endtask

  task automatic t_small();
    setup(8'h46, 8'h60, 8'h46, 8'h47);
    good_pkt("R3 short", 10, 8'hA0, 8'h47, 8'h46, 8'h60, 8'h48);
    chk("R3 first byte at offset 4", rdm(16'h4704), 8'hA0);
  endtask

  task automatic t_span();
    setup(8'h46, 8'h60, 8'h46, 8'h48);
    good_pkt("R4 span", 300, 8'h10, 8'h48, 8'h46, 8'h60, 8'h4A);
    chk("R4 byte at next page offset 0", rdm(16'h4900), int'(8'(8'h10 + 252)));
  endtask

  task automatic t_wrap();
    setup(8'h46, 8'h4C, 8'h47, 8'h4B);
    good_pkt("R4 wrap", 300, 8'h33, 8'h4B, 8'h46, 8'h4C, 8'h47);
    chk("R4 wrapped byte at start page", rdm(16'h4600), int'(8'(8'h33 + 252)));
  endtask

  task automatic t_ovf();
    int v, d0 = done_cnt, o0 = ovf_cnt;
    setup(8'h46, 8'h60, 8'h48, 8'h47);
    send(300, 8'h5A);
    chk("R5 overflow pulses", ovf_cnt - o0, 1);
    chk("R5 no done", done_cnt - d0, 0);
    chk("R5 boundary page untouched", rdm(16'h4800), -1);
    chk("R5 no header", rdm(16'h4700), -1);
    chk("R5 data before boundary kept", rdm(16'h4704), 8'h5A);
    rreg(2'd3, v); chk("R5 current unchanged", v, 8'h47);
  endtask

  task automatic t_exact();
    int o0 = ovf_cnt;
    setup(8'h46, 8'h60, 8'h49, 8'h48);
    good_pkt("R7 exact fill", 252, 8'h01, 8'h48, 8'h46, 8'h60, 8'h49);
    chk("R7 exact fill no overflow", ovf_cnt - o0, 0);
  endtask

  task automatic t_stopped();
    int v, d0 = done_cnt;
    setup(8'h46, 8'h60, 8'h46, 8'h47);
    @(negedge clk) rx_enable = 1'b0;
    send(5, 8'h77);
    chk("R8 no writes while stopped", mem.size(), 0);
    chk("R8 no done while stopped", done_cnt - d0, 0);
    rreg(2'd3, v); chk("R8 current unchanged", v, 8'h47);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_small();
    t_span();
    t_wrap();
    t_ovf();
    t_exact();
    t_stopped();
    finish_up();
  end
endmodule